// File: doc/BRIEF.md
# Manchester Frame Transmitter for a 212/424 kbit/s Contactless Link

This block builds one transmit frame and sends it serially on a single modulation output. The host first pushes a length byte into an internal byte FIFO, then the payload bytes. A start pulse then launches the frame. The block creates the run-in and the two-byte sync pattern by itself and never reads them from the FIFO. It then streams the length byte and the payload from the FIFO, keeps a 16-bit CRC over them, and appends that CRC. Every bit goes out Manchester-coded.

The link runs at one of two bit rates, chosen by `rate_i`, with the bit period counted in cycles of a 13.56 MHz clock. The block latches the rate when it accepts the start pulse. The length byte counts itself, so the block fetches as many further bytes as the length value minus one. If the FIFO is empty when the serializer needs its next byte, the frame stops and an error flag is set.

Top module: `manch_frame_tx`

## Requirements
- R1: A frame opens with six 0x00 bytes, then 0xB2, then 0x4D. Every byte of the frame goes out MSB first, and none of these eight bytes is taken from the FIFO.
- R2: Each bit lasts P clock cycles, where P = 64 when `rate_i` = 0 and P = 32 when `rate_i` = 1. A 1 is sent as high for P/2 cycles and then low for P/2 cycles. A 0 is sent as low and then high. The rate is sampled only when a start is accepted.
- R3: After the sync bytes, the block pops the length byte L from the FIFO and sends it, then pops and sends L-1 payload bytes. L = 0 is treated as having no payload.
- R4: The two bytes after the payload are a CRC with generator x^16+x^12+x^5+1, preset to 0x0000, processed MSB first over the length byte and the payload. The high byte is sent first.
- R5: `busy_o` goes high in the cycle after an accepted start and stays high until the last half-bit of the CRC low byte ends. `done_o` is high for exactly the one cycle that follows.
- R6: A start pulse while `busy_o` is high is ignored. The running frame, its bit rate and its end time do not change.
- R7: If the FIFO is empty when a byte must be fetched, the frame aborts at that byte boundary. `busy_o` drops, `tx_o` is low, `done_o` stays low, and `underflow_o` is set. `underflow_o` stays set until the next accepted start clears it.
- R8: After reset, `busy_o`, `done_o`, `underflow_o` and `tx_o` are low and the FIFO is empty.
- R9: `tx_o` is low whenever `busy_o` is low.
- R10: A write while the FIFO holds FIFO_DEPTH bytes is dropped, and `full_o` is high in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 13.56 MHz bit-timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 1 | 0: 64 cycles per bit, 1: 32 cycles per bit |
| start_i | input | 1 | Start a frame (used only when idle) |
| wr_i | input | 1 | Push `wdata_i` into the FIFO |
| wdata_i | input | 8 | FIFO write data |
| full_o | output | 1 | FIFO holds FIFO_DEPTH bytes |
| tx_o | output | 1 | Manchester modulation output |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| underflow_o | output | 1 | Frame aborted on an empty FIFO |

## Verification
Counting from the clock edge that accepts the start, bit b of the frame occupies cycles b*P to b*P+P-1 after that edge. Because `tx_o` is a direct function of registered state, the bench samples each half-bit a quarter period into it: at b*P+P/4 and at b*P+3P/4. With n bytes sent, `busy_o` falls, and either `done_o` or `underflow_o` rises, exactly n*8*P cycles after the start edge. The bench checks those outputs at that cycle, and checks `done_o` again one cycle later. All sampling happens at the falling edge, so the registered outputs are already settled.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int unsigned PRE_BYTES = 6;
  localparam logic [7:0]  SYNC_A    = 8'hB2;
  localparam logic [7:0]  SYNC_B    = 8'h4D;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  typedef enum logic [2:0] {
    PH_PRE, PH_SYNC_A, PH_SYNC_B, PH_LEN, PH_DATA, PH_CRC_HI, PH_CRC_LO
  } phase_e;
endpackage

// File: rtl/mft_fifo.sv
module mft_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/mft_crc16.sv
module mft_crc16 import mft_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q ^ {data_i, 8'h00};
    for (int i = 0; i < 8; i++)
      crc_d = crc_d[15] ? ((crc_d << 1) ^ CRC_POLY) : (crc_d << 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (upd_i)   crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/mft_bit_timer.sv
module mft_bit_timer #(
  parameter int SLOW_CYC = 64,
  parameter int FAST_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic half2_o,
  output logic bit_end_o
);
  localparam int CW = $clog2(SLOW_CYC);

  logic [CW-1:0] cnt_q, limit;

  assign limit     = fast_i ? CW'(FAST_CYC-1) : CW'(SLOW_CYC-1);
  assign half2_o   = fast_i ? (cnt_q >= CW'(FAST_CYC/2)) : (cnt_q >= CW'(SLOW_CYC/2));
  assign bit_end_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R2: a bit never outlasts its period
  a_r2_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= limit));
endmodule

// File: rtl/manch_frame_tx.sv
module manch_frame_tx import mft_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int SLOW_CYC   = 64,
  parameter int FAST_CYC   = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rate_i,
  input  logic       start_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       full_o,
  output logic       tx_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       underflow_o
);
  localparam int PW = $clog2(PRE_BYTES + 1);

  phase_e      phase_q;
  logic        busy_q, done_q, uflow_q, rate_q;
  logic [7:0]  shift_q, left_q;
  logic [2:0]  bit_q;
  logic [PW-1:0] pre_q;

  logic        fifo_empty, fifo_pop, need_fifo, start_acc;
  logic [7:0]  fifo_data;
  logic [15:0] crc;
  logic        half2, bit_end, byte_end;

  mft_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) i_fifo (
    .clk_i, .rst_ni, .wr_i, .wdata_i,
    .rd_i(fifo_pop), .rdata_o(fifo_data), .empty_o(fifo_empty), .full_o
  );

  mft_crc16 i_crc (
    .clk_i, .rst_ni, .clear_i(start_acc), .upd_i(fifo_pop),
    .data_i(fifo_data), .crc_o(crc)
  );

  mft_bit_timer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) i_timer (
    .clk_i, .rst_ni, .run_i(busy_q), .fast_i(rate_q),
    .half2_o(half2), .bit_end_o(bit_end)
  );

  assign start_acc = start_i && !busy_q;
  assign byte_end  = bit_end && (bit_q == 3'd7);
  assign need_fifo = byte_end && ((phase_q == PH_SYNC_B) ||
                     (((phase_q == PH_LEN) || (phase_q == PH_DATA)) && (left_q != 8'd0)));
  assign fifo_pop  = need_fifo && !fifo_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PRE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      uflow_q <= 1'b0;
      rate_q  <= 1'b0;
      shift_q <= '0;
      left_q  <= '0;
      bit_q   <= '0;
      pre_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        busy_q  <= 1'b1;
        uflow_q <= 1'b0;
        rate_q  <= rate_i;
        phase_q <= PH_PRE;
        pre_q   <= '0;
        shift_q <= 8'h00;
        bit_q   <= '0;
      end else if (busy_q && bit_end) begin
        if (!byte_end) begin
          shift_q <= shift_q << 1;
          bit_q   <= bit_q + 1'b1;
        end else begin
          bit_q <= '0;
          if (need_fifo && fifo_empty) begin
            busy_q  <= 1'b0;
            uflow_q <= 1'b1;
          end else begin
            case (phase_q)
              PH_PRE: begin
                if (pre_q == PW'(PRE_BYTES-1)) begin
                  phase_q <= PH_SYNC_A;
                  shift_q <= SYNC_A;
                end else begin
                  pre_q   <= pre_q + 1'b1;
                  shift_q <= 8'h00;
                end
              end
              PH_SYNC_A: begin
                phase_q <= PH_SYNC_B;
                shift_q <= SYNC_B;
              end
              PH_SYNC_B: begin
                phase_q <= PH_LEN;
                shift_q <= fifo_data;
                left_q  <= (fifo_data == 8'd0) ? 8'd0 : fifo_data - 8'd1;
              end
              PH_LEN, PH_DATA: begin
                if (left_q != 8'd0) begin
                  phase_q <= PH_DATA;
                  shift_q <= fifo_data;
                  left_q  <= left_q - 8'd1;
                end else begin
                  phase_q <= PH_CRC_HI;
                  shift_q <= crc[15:8];
                end
              end
              PH_CRC_HI: begin
                phase_q <= PH_CRC_LO;
                shift_q <= crc[7:0];
              end
              default: begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assign tx_o        = busy_q && (shift_q[7] ^ half2);
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign underflow_o = uflow_q;

  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r6_rate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (rate_q == $past(rate_q)));
  a_r7_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (!busy_o && !done_o));
  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tx_o);
  a_r3_pop_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop |-> busy_q);
endmodule

// File: tb/test_manch_frame_tx.sv
`timescale 1ns/1ps
module test_manch_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rate = 1'b0, start = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic full, tx, busy, done, uflow;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_b [300];
  int exp_n;

  always #4 clk = ~clk;

  manch_frame_tx i_manch_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .start_i(start),
    .wr_i(wr), .wdata_i(wdata), .full_o(full), .tx_o(tx),
    .busy_o(busy), .done_o(done), .underflow_o(uflow)
  );

  // rate, length, payload seed
  localparam logic [23:0] VEC [5] = '{
    {8'd0, 8'd1,  8'h00},
    {8'd1, 8'd5,  8'h3C},
    {8'd0, 8'd4,  8'hA5},
    {8'd1, 8'd12, 8'h81},
    {8'd1, 8'd0,  8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 37);
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk); wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic head;
    for (int i = 0; i < 6; i++) exp_b[i] = 8'h00;
    exp_b[6] = 8'hB2;
    exp_b[7] = 8'h4D;
  endtask

  // sends exp_n bytes; ends in done (ab=0) or underflow (ab=1)
  task automatic run(input bit r, input bit ab, input int glitch_k);
    int p = r ? 32 : 64;
    int t = exp_n * 8 * p;
    @(negedge clk); rate = r; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R5 busy after start", busy, 1);
    chk(uflow === 1'b0, "R7 uflow cleared", uflow, 0);
    for (int k = 0; k < t; k++) begin
      if (k > 0) @(negedge clk);
      if (k % p == p/4 || k % p == 3*p/4) begin
        int b = k / p;
        logic bv = exp_b[b/8][7 - (b%8)];
        logic ev = (k % p == p/4) ? bv : ~bv;
        chk(tx === ev, "R1 R2 R3 R4 tx half-bit", tx, ev);
      end
      if (k == glitch_k) begin start = 1'b1; rate = ~r; end
      else if (k == glitch_k + 1) start = 1'b0;
    end
    @(negedge clk);
    chk(busy === 1'b0, "R5 busy end", busy, 0);
    chk(done === !ab, "R5 R7 done at end", done, !ab);
    chk(uflow === ab, "R7 underflow flag", uflow, ab);
    chk(tx === 1'b0, "R9 tx idle", tx, 0);
    @(negedge clk);
    chk(done === 1'b0, "R5 done single cycle", done, 0);
    chk(uflow === ab, "R7 flag held", uflow, ab);
  endtask

  task automatic load_frame(input logic [7:0] len, input logic [7:0] seed, input int npush);
    logic [15:0] c = '0;
    int np = (len == 0) ? 0 : len - 1;
    head();
    exp_b[8] = len;
    c = crc_step(c, len);
    push(len);
    for (int i = 0; i < np; i++) begin
      exp_b[9+i] = pay(seed, i);
      c = crc_step(c, pay(seed, i));
      if (i < npush) push(pay(seed, i));
    end
    exp_b[9+np]  = c[15:8];
    exp_b[10+np] = c[7:0];
    exp_n = 11 + np;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy === 1'b0 && done === 1'b0, "R8 reset busy/done", {busy, done}, 0);
    chk(uflow === 1'b0 && tx === 1'b0, "R8 reset uflow/tx", {uflow, tx}, 0);
    chk(full === 1'b0, "R8 reset fifo", full, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of frames
    for (int v = 0; v < 5; v++) begin
      load_frame(VEC[v][15:8], VEC[v][7:0], 255);
      run(VEC[v][16], 1'b0, -10);
    end

    // R7: empty FIFO at length fetch
    head(); exp_n = 8;
    run(1'b1, 1'b1, -10);

    // R7: underflow mid payload (len 3, one payload byte given)
    load_frame(8'd3, 8'h55, 1);
    exp_n = 10;
    run(1'b1, 1'b1, -10);

    // R6: start and rate flip mid-frame are ignored
    load_frame(8'd3, 8'h12, 255);
    run(1'b1, 1'b0, 1000);

    // R10: fill, overfill, then drain; the dropped byte must not remain
    load_frame(8'd16, 8'h6B, 255);
    chk(full === 1'b1, "R10 full flag", full, 1);
    push(8'hEE);
    chk(full === 1'b1, "R10 still full", full, 1);
    run(1'b1, 1'b0, -10);
    chk(full === 1'b0, "R10 drained", full, 0);
    head(); exp_n = 8;
    run(1'b1, 1'b1, -10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule